// File: doc/BRIEF.md
# Scrambled Two-Stream PAM4 Transmit Datapath

This block is the digital core of a fast optical transmitter. Sixteen slow parallel lanes are sampled once per frame and scrambled with a single 7-bit pseudo-random sequence. They are then split across two serializers that share one fast clock and step through their eight lanes together. In every symbol period the two serial bits are merged into one 4-level symbol, so the symbol rate is half the aggregate bit rate. In the reduced-rate mode only the first serializer carries data, and the line uses only its two outer levels.

The same pseudo-random sequence also serves as the frame-alignment reference. An alignment mode blanks the payload so that every lane carries the raw sequence. A companion receive checker is built into the block for self-test. It frames on the start-of-frame strobe and decodes the symbols. It locks by predicting each lane-0 bit from the seven bits before it, then descrambles every lane and reports bit errors in alignment frames. A single-bit line-error input stands in for a noisy channel between the transmitter and the checker. The PLL, the analog driver, the laser and real multi-GHz timing are all treated as ideal.

Top module: `pam4_scram_tx`

## Requirements
- R1: While `rst_n` is low, `sym_level` is 0 and `sym_sof`, `rx_valid` and `rx_lock` are all 0.
- R2: The scrambler sequence uses x^7 + x^6 + 1. Its state starts at all ones after reset, its output bit is the state MSB, it advances once per frame and its state is never all zero. The bit for frame n is XORed into every lane of frame n.
- R3: Number the clock edges after reset release from 0. `lane_in` is sampled at edges 8n, and slot j of that frame is on the line after edge 8n+1+j. `sym_sof` is high exactly for slot 0.
- R4: In slot j, serializer A carries lane j and serializer B carries lane j+8. The Gray map from bits (A,B) to level is 00→0, 01→1, 11→2 and 10→3. `sym_level` gives the level as a 2-bit binary index.
- R5: While `align_en` is high at the sampling edge, `lane_in` is ignored and every lane of that frame carries the raw sequence bit.
- R6: While `half_rate` is high at the sampling edge, lanes 8–15 are ignored and the B bit is 0, so that frame uses only levels 0 and 3.
- R7: The checker raises `rx_valid` for one cycle per frame. For the frame sampled at edge 8n it does so after edge 8n+9.
- R8: `rx_lock` rises only after 127 consecutive correct lane-0 predictions, so never on frames 0–126 when align runs from reset. Within 140 frames of aligned traffic it has risen, and it then stays high until reset.
- R9: When locked, `rx_data` equals the frame's payload. Lanes 8–15 read 0 in reduced-rate frames, and all lanes read 0 in alignment frames.
- R10: When `line_err` is high, the MSB of the level index seen by the checker is inverted. `rx_bit_err` is asserted with `rx_valid` only if the checker was already locked, the frame is an alignment frame, and some descrambled bit is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared fast symbol clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lane_in | input | 16 | Parallel payload lanes, sampled once per frame |
| align_en | input | 1 | Blank payload so lanes carry the raw sequence |
| half_rate | input | 1 | Reduced-rate mode, serializer A only |
| line_err | input | 1 | Channel-error stand-in, inverts level MSB into checker |
| sym_level | output | 2 | PAM4 level index for the driver |
| sym_sof | output | 1 | Start-of-frame strobe on the lane-0 symbol |
| rx_valid | output | 1 | Checker frame-complete pulse |
| rx_data | output | 16 | Checker descrambled lanes |
| rx_lock | output | 1 | Checker locked to the sequence |
| rx_bit_err | output | 1 | Checker error flag in a locked alignment frame |

## Verification
The assertions take three things for granted. First, the checker sees an unbroken stream in which a strobe arrives every eight symbols. Second, mode inputs matter only at frame sampling edges. Third, `line_err` is the only way the line can be corrupted. The stimulus respects this. It changes `align_en` and `half_rate` freely, but the bench treats each value as a tag of the frame sampled at that edge. It runs in alignment from reset long enough to lock. It injects exactly one line error, on a lane-0 symbol of a frame it has identified, and then switches to random payload in both rate modes.

// File: rtl/pam4_tx_pkg.sv
// Package: shared level type and Gray mapping between bit pairs and
// PAM4 level indices. Assumes level index 0 is the lowest optical level.
package pam4_tx_pkg;

    typedef logic [1:0] pam4_level_t;

    localparam pam4_level_t LEVEL_IDLE = 2'd0;

    // Gray map: (msb,lsb) 00->0, 01->1, 11->2, 10->3
    function automatic pam4_level_t gray_encode(input logic msb, input logic lsb);
        return {msb, msb ^ lsb};
    endfunction

    // Inverse map: MSB of the bit pair
    function automatic logic gray_msb(input pam4_level_t lvl);
        return lvl[1];
    endfunction

    // Inverse map: LSB of the bit pair
    function automatic logic gray_lsb(input pam4_level_t lvl);
        return lvl[1] ^ lvl[0];
    endfunction

endpackage

// File: rtl/prbs_gen.sv
// Module: Fibonacci pseudo-random generator, one step per advance pulse.
// Polynomial x^W + x^TAP + 1, all-ones seed at reset. An all-zero state
// is never legal and triggers a reseed. The output bit is the state MSB.
module prbs_gen #(
    parameter int W   = 7,
    parameter int TAP = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic advance,
    output logic bit_o
);

    logic [W-1:0] state_q;

    // Purpose: step the register once per frame, recovering from all-zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '1;
        end else if (state_q == '0) begin
            state_q <= '1;
        end else if (advance) begin
            state_q <= {state_q[W-2:0], state_q[W-1] ^ state_q[TAP-1]};
        end
    end

    assign bit_o = state_q[W-1];

    assert_prbs_nonzero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/ser_lane_mux.sv
// Module: one serializer. Holds a frame of LPS scrambled lane bits and
// emits the bit picked by the shared slot counter. A disabled serializer
// loads zeros, which the mapper reads as a 0 LSB.
module ser_lane_mux #(
    parameter int LPS    = 8,
    localparam int SLOT_W = $clog2(LPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              enable,
    input  logic [LPS-1:0]    frame_in,
    input  logic [SLOT_W-1:0] slot,
    output logic              bit_o
);

    logic [LPS-1:0] frame_q;

    // Purpose: capture one frame of lane bits at the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (load) begin
            frame_q <= enable ? frame_in : '0;
        end
    end

    assign bit_o = frame_q[slot];

endmodule

// File: rtl/frame_checker.sv
// Module: receive-side self-check. Frames on the strobe, undoes the Gray
// map and gathers one frame of lane bits. While unlocked it predicts each
// lane-0 bit from the previous seven received bits, and locks after
// LOCK_RUN consecutive hits. Once locked the predictor free-runs and every
// lane is descrambled. Assumes a strobe every LANES/2 symbols.
module frame_checker
    import pam4_tx_pkg::*;
#(
    parameter int LANES    = 16,
    parameter int PRBS_W   = 7,
    parameter int PRBS_TAP = 6,
    parameter int LOCK_RUN = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pam4_level_t      sym,
    input  logic             sof,
    input  logic             half_tag,
    input  logic             align_tag,
    output logic             rx_valid,
    output logic [LANES-1:0] rx_data,
    output logic             rx_lock,
    output logic             rx_bit_err
);

    localparam int LPS    = LANES / 2;
    localparam int SLOT_W = $clog2(LPS);
    localparam int RUN_W  = $clog2(LOCK_RUN + 1);

    logic              framed_q;
    logic [SLOT_W-1:0] idx_q;
    logic [LPS-1:0]    buf_a_q, buf_b_q;
    logic [LPS-1:0]    full_a, full_b;
    logic [PRBS_W-1:0] hist_q;
    logic [RUN_W-1:0]  run_q;
    logic              locked_q;
    logic              a_bit, b_bit, frame_done, pred, hit;
    logic [LANES-1:0]  descr;

    assign a_bit      = gray_msb(sym);
    assign b_bit      = gray_lsb(sym);
    assign frame_done = framed_q && !sof && (idx_q == SLOT_W'(LPS - 1));
    assign pred       = hist_q[PRBS_W-1] ^ hist_q[PRBS_TAP-1];
    assign hit        = (full_a[0] == pred);

    // Purpose: assemble the complete frame with the current last symbol
    always_comb begin
        full_a        = buf_a_q;
        full_b        = buf_b_q;
        full_a[LPS-1] = a_bit;
        full_b[LPS-1] = b_bit;
        descr         = {full_b, full_a} ^ {LANES{pred}};
        if (half_tag) begin
            descr[LANES-1:LPS] = '0;
        end
    end

    // Purpose: track symbol position and collect lane bits per slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            framed_q <= 1'b0;
            idx_q    <= '0;
            buf_a_q  <= '0;
            buf_b_q  <= '0;
        end else if (sof) begin
            framed_q   <= 1'b1;
            idx_q      <= SLOT_W'(1);
            buf_a_q[0] <= a_bit;
            buf_b_q[0] <= b_bit;
        end else if (frame_done) begin
            idx_q <= '0;
        end else if (framed_q) begin
            buf_a_q[idx_q] <= a_bit;
            buf_b_q[idx_q] <= b_bit;
            idx_q          <= idx_q + SLOT_W'(1);
        end
    end

    // Purpose: slide to the received sequence, then free-run once locked
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q   <= '0;
            run_q    <= '0;
            locked_q <= 1'b0;
        end else if (frame_done) begin
            if (locked_q) begin
                hist_q <= {hist_q[PRBS_W-2:0], pred};
            end else begin
                hist_q <= {hist_q[PRBS_W-2:0], full_a[0]};
                if (hit && hist_q != '0) begin
                    run_q <= run_q + RUN_W'(1);
                    if (run_q == RUN_W'(LOCK_RUN - 1)) begin
                        locked_q <= 1'b1;
                    end
                end else begin
                    run_q <= '0;
                end
            end
        end
    end

    // Purpose: register per-frame results
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_valid   <= 1'b0;
            rx_data    <= '0;
            rx_bit_err <= 1'b0;
        end else begin
            rx_valid   <= frame_done;
            rx_bit_err <= frame_done && locked_q && align_tag && (descr != '0);
            if (frame_done) begin
                rx_data <= descr;
            end
        end
    end

    assign rx_lock = locked_q;

    assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_lock_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_lock |=> rx_lock);

    assert_err_needs_lock_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_bit_err |-> (rx_lock && rx_valid));

endmodule

// File: rtl/pam4_scram_tx.sv
// Module: top of the transmit datapath. A shared slot counter frames
// LANES/2 symbol periods. At each frame boundary the lanes are blanked
// (align) or masked (half rate) and scrambled with the sequence bit, then
// loaded into two lockstep serializers. Their bits are Gray mapped into
// a registered PAM4 level. Frame mode tags travel with the symbols to
// the built-in checker. Assumes mode inputs matter only at frame loads.
module pam4_scram_tx
    import pam4_tx_pkg::*;
#(
    parameter int NUM_LANES = 16,
    parameter int PRBS_W    = 7,
    parameter int PRBS_TAP  = 6,
    parameter int LOCK_RUN  = 127
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LANES-1:0] lane_in,
    input  logic                 align_en,
    input  logic                 half_rate,
    input  logic                 line_err,
    output logic [1:0]           sym_level,
    output logic                 sym_sof,
    output logic                 rx_valid,
    output logic [NUM_LANES-1:0] rx_data,
    output logic                 rx_lock,
    output logic                 rx_bit_err
);

    localparam int NUM_SER = 2;
    localparam int LPS     = NUM_LANES / NUM_SER;
    localparam int SLOT_W  = $clog2(LPS);

    logic [SLOT_W-1:0]    slot_q;
    logic                 frame_load, prbs_bit;
    logic [NUM_LANES-1:0] payload, scrambled;
    logic [NUM_SER-1:0]   ser_bit;
    logic                 half_q, align_q;
    pam4_level_t          sym_q, line_sym;
    logic                 sof_q, tag_half_q, tag_align_q;

    assign frame_load = (slot_q == SLOT_W'(LPS - 1));

    // Purpose: shared slot counter, parked on the last slot in reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= SLOT_W'(LPS - 1);
        end else if (frame_load) begin
            slot_q <= '0;
        end else begin
            slot_q <= slot_q + SLOT_W'(1);
        end
    end

    prbs_gen #(.W(PRBS_W), .TAP(PRBS_TAP)) u_prbs (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (frame_load),
        .bit_o   (prbs_bit)
    );

    assign payload   = align_en ? '0 : lane_in;
    assign scrambled = payload ^ {NUM_LANES{prbs_bit}};

    for (genvar g = 0; g < NUM_SER; g++) begin : g_ser
        ser_lane_mux #(.LPS(LPS)) u_ser (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (frame_load),
            .enable   ((g == 0) ? 1'b1 : !half_rate),
            .frame_in (scrambled[g*LPS +: LPS]),
            .slot     (slot_q),
            .bit_o    (ser_bit[g])
        );
    end

    // Purpose: hold the mode tags of the frame being serialized
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q  <= 1'b0;
            align_q <= 1'b0;
        end else if (frame_load) begin
            half_q  <= half_rate;
            align_q <= align_en;
        end
    end

    // Purpose: register the PAM4 level, strobe and tags for the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_q       <= LEVEL_IDLE;
            sof_q       <= 1'b0;
            tag_half_q  <= 1'b0;
            tag_align_q <= 1'b0;
        end else begin
            sym_q       <= gray_encode(ser_bit[0], ser_bit[1]);
            sof_q       <= (slot_q == '0);
            tag_half_q  <= half_q;
            tag_align_q <= align_q;
        end
    end

    assign sym_level = sym_q;
    assign sym_sof   = sof_q;
    assign line_sym  = {sym_q[1] ^ line_err, sym_q[0]};

    frame_checker #(
        .LANES    (NUM_LANES),
        .PRBS_W   (PRBS_W),
        .PRBS_TAP (PRBS_TAP),
        .LOCK_RUN (LOCK_RUN)
    ) u_chk (
        .clk        (clk),
        .rst_n      (rst_n),
        .sym        (line_sym),
        .sof        (sof_q),
        .half_tag   (tag_half_q),
        .align_tag  (tag_align_q),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .rx_lock    (rx_lock),
        .rx_bit_err (rx_bit_err)
    );

    assert_half_outer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tag_half_q |-> (sym_q == 2'd0 || sym_q == 2'd3));

endmodule

// File: tb/pam4_scram_tx_test.sv
module pam4_scram_tx_test;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] lane_in = '0;
    logic        align_en = 1'b1;
    logic        half_rate = 1'b0;
    logic        line_err = 1'b0;
    logic [1:0]  sym_level;
    logic        sym_sof;
    logic        rx_valid;
    logic [15:0] rx_data;
    logic        rx_lock;
    logic        rx_bit_err;

    int compared = 0;
    int mismatched = 0;
    int rx_cnt = 0;
    int err_frame = -1;
    int edge_n = 0;
    int pst = 127;
    bit prev_lock = 0;
    bit finished = 0;

    logic [2:0]  symq[$];
    logic [17:0] payq[$];

    pam4_scram_tx uut (
        .clk(clk), .rst_n(rst_n), .lane_in(lane_in), .align_en(align_en),
        .half_rate(half_rate), .line_err(line_err), .sym_level(sym_level),
        .sym_sof(sym_sof), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_lock(rx_lock), .rx_bit_err(rx_bit_err)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // Reference model: expected line symbols and payloads, checked every clock
    always @(posedge clk) begin
        if (!rst_n) begin
            edge_n = 0;
            pst = 127;
            symq.delete();
            symq.push_back(3'b000);
            payq.delete();
            rx_cnt = 0;
            prev_lock = 0;
            #1;
            check(sym_level == 2'd0 && !sym_sof, "R1 line", {sym_sof, sym_level}, 0);
            check(!rx_valid && !rx_lock, "R1 checker", {rx_valid, rx_lock}, 0);
        end else begin
            logic [2:0] exp_s;
            string tag;
            exp_s = symq.pop_front();
            tag = align_en ? "R2 R5" : (half_rate ? "R6" : "R4");
            if (edge_n % 8 == 0) begin
                logic [15:0] pay, scr;
                bit pb;
                pb = (pst >> 6) & 1;
                pst = ((pst << 1) & 127) | (((pst >> 6) ^ (pst >> 5)) & 1);
                pay = align_en ? 16'h0 : (half_rate ? {8'h00, lane_in[7:0]} : lane_in);
                scr = pay ^ {16{pb}};
                for (int s = 0; s < 8; s++) begin
                    logic a, b;
                    a = scr[s];
                    b = half_rate ? 1'b0 : scr[8+s];
                    symq.push_back({(s == 0), a, a ^ b});
                end
                payq.push_back({align_en, 1'b0, pay});
            end
            edge_n++;
            #1;
            check(sym_level == exp_s[1:0], tag, sym_level, exp_s[1:0]);
            check(sym_sof == exp_s[2], "R3", sym_sof, exp_s[2]);
            if (rx_valid) begin
                logic [17:0] ent;
                ent = payq.pop_front();
                check(edge_n == 8*rx_cnt + 10, "R7 latency", edge_n, 8*rx_cnt + 10);
                if (rx_cnt <= 126) check(!rx_lock, "R8 early", rx_lock, 0);
                if (rx_cnt == 140) check(rx_lock, "R8 lock", rx_lock, 1);
                if (prev_lock && rx_cnt != err_frame)
                    check(rx_data == ent[15:0], "R9 data", rx_data, ent[15:0]);
                check(rx_bit_err == (prev_lock && ent[17] && rx_cnt == err_frame),
                      "R10 err", rx_bit_err, prev_lock && ent[17] && rx_cnt == err_frame);
                if (prev_lock) check(rx_lock, "R8 sticky", rx_lock, 1);
                prev_lock = rx_lock;
                rx_cnt++;
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        lane_in = 16'($urandom);
    endtask

    task automatic wait_frames(input int n);
        int target;
        target = rx_cnt + n;
        while (rx_cnt < target) tick();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        repeat (5) tick();
        rst_n = 1'b1;
        // Aligned traffic from reset: lock window (R8), inputs ignored (R5)
        wait_frames(142);
        // One line error on lane 0 of the next frame (R10)
        @(posedge clk); #2;
        while (!rx_valid) begin @(posedge clk); #2; end
        err_frame = rx_cnt;
        @(negedge clk); line_err = 1'b1;
        @(negedge clk); line_err = 1'b0;
        wait_frames(4);
        // Random payload at full rate (R4, R9)
        @(negedge clk); align_en = 1'b0;
        wait_frames(20);
        // Reduced rate (R6, R9)
        @(negedge clk); half_rate = 1'b1;
        wait_frames(20);
        // Back to aligned full rate, no errors expected (R10)
        @(negedge clk); half_rate = 1'b0; align_en = 1'b1;
        wait_frames(6);
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog actual=0 expected=1");
        finish_run();
    end

endmodule